// File: doc/BRIEF.md
# Multi-Queue Linked-List FIFO Controller

This block keeps sixteen independent first-in first-out queues inside one shared storage array of 64 entries. No queue owns a fixed slice of memory. Every entry holds an 8-bit data word and a 6-bit link to the next entry. Unused entries sit on a single free list. Each channel keeps a head register, a tail register and a non-empty bit that describe its own chain of entries. A push takes the entry at the front of the free list, writes the data into it and appends it to the tail of the named channel. A pop removes the head entry of the named channel, returns its data and puts the entry back on the front of the free list. As a result, one channel may hold every entry, or the entries may be spread over all sixteen channels.

A requester presents one operation at a time, either a push or a pop, together with a channel number. A valid operation is accepted on any rising edge where `busy` is low. An accepted operation runs a fixed two-cycle sequence. The first cycle reads or updates the link. The second cycle updates the head, tail and free-list pointers. `busy` stays high for the whole sequence. Two kinds of request are rejected at once and leave every list unchanged: a push while the array is full, and a pop on an empty channel. Each rejection is reported by a one-cycle error pulse.

Top module: `llq_ctrl`

## Requirements
- R1: After reset every bit of `chan_empty` is 1, and `full`, `busy`, `rsp_valid`, `err_full` and `err_empty` are 0. The free list then holds all 64 entries.
- R2: A request with `req_valid`=1 at a rising edge where `busy`=0 is accepted at that edge, unless R6 or R7 rejects it. `busy` is then 1 for exactly the two following clock cycles. Requests presented while `busy`=1 are ignored.
- R3: Pops on one channel return data words in the order in which that channel's pushes supplied them. `req_push`=1 selects push and `req_push`=0 selects pop.
- R4: Pushes and pops on one channel do not change the contents or the order of any other channel, whatever the interleaving.
- R5: `chan_empty[c]` falls when a push to channel c completes, and rises when the pop that removes the last entry of channel c completes. Completion is the end of the second busy cycle.
- R6: `full` is 1 exactly when all 64 entries are in use. A push accepted while `full`=1 does not raise `busy`. It gives a one-cycle `err_full` pulse in the cycle after the edge, and it changes no queue.
- R7: A pop on a channel whose `chan_empty` bit is 1 does not raise `busy`. It gives a one-cycle `err_empty` pulse in the cycle after the edge, and it changes no queue.
- R8: A completed pop returns its entry to the free list. After a pop while the array is full, `full` is 0 and a push to any channel succeeds. A single channel can hold all 64 entries.
- R9: For an accepted pop, `rsp_valid` is 1 for exactly one cycle: the cycle right after the second busy cycle. During that cycle `rsp_data` holds the popped word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operation request |
| req_push | input | 1 | 1 = push, 0 = pop |
| req_chan | input | 4 | Channel number of the operation |
| req_data | input | 8 | Data word for a push |
| busy | output | 1 | Sequence in progress; new requests ignored |
| rsp_valid | output | 1 | One-cycle pulse when a pop completes |
| rsp_data | output | 8 | Word removed by the latest pop |
| full | output | 1 | No free entries remain |
| chan_empty | output | 16 | Per-channel empty flags |
| err_full | output | 1 | Push rejected because the array was full |
| err_empty | output | 1 | Pop rejected because the channel was empty |

## Verification
Any corrupted link or pointer shows up at the ports on the next pop of the affected channel: a word comes back from the wrong channel or out of order. A lost or duplicated free entry stays hidden until the array is filled. It then appears as `full` rising too early or too late, or as words overwritten during the refill. For this reason the bench fills one channel to capacity, rejects a push, frees one entry and drains everything while checking every word. A sequencing fault shows within three cycles of acceptance as a wrong `busy` length or a misplaced `rsp_valid`.

// File: rtl/llq_ctrl.sv
module llq_ctrl #(
  parameter int NCH   = 16,
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_push,
  input  logic [$clog2(NCH)-1:0]   req_chan,
  input  logic [DW-1:0]            req_data,
  output logic                     busy,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_data,
  output logic                     full,
  output logic [NCH-1:0]           chan_empty,
  output logic                     err_full,
  output logic                     err_empty
);
  localparam int CW   = $clog2(NCH);
  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_LINK, S_UPD} st_t;

  st_t            st;
  logic           op_push;
  logic [CW-1:0]  op_ch;
  logic [DW-1:0]  op_data;
  logic [AW-1:0]  ent, nxt;
  logic [AW-1:0]  free_head;
  logic [CNTW-1:0] free_cnt;
  logic [AW-1:0]  head [NCH];
  logic [AW-1:0]  tail [NCH];
  logic [NCH-1:0] nonempty;
  logic [DW-1:0]  mem_data [DEPTH];
  logic [AW-1:0]  mem_next [DEPTH];

  wire accept  = req_valid && (st == S_IDLE);
  wire push_ok = accept && req_push && !full;
  wire pop_ok  = accept && !req_push && nonempty[req_chan];

  assign busy       = (st != S_IDLE);
  assign full       = (free_cnt == '0);
  assign chan_empty = ~nonempty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_push   <= 1'b0;
      op_ch     <= '0;
      op_data   <= '0;
      ent       <= '0;
      nxt       <= '0;
      free_head <= '0;
      free_cnt  <= CNTW'(DEPTH);
      nonempty  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      err_full  <= 1'b0;
      err_empty <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        head[c] <= '0;
        tail[c] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      err_full  <= accept && req_push && full;
      err_empty <= accept && !req_push && !nonempty[req_chan];
      case (st)
        S_IDLE: if (push_ok || pop_ok) begin
          st      <= S_LINK;
          op_push <= req_push;
          op_ch   <= req_chan;
          op_data <= req_data;
        end
        S_LINK: begin
          st <= S_UPD;
          if (op_push) begin
            ent <= free_head;
            nxt <= mem_next[free_head];
          end else begin
            ent      <= head[op_ch];
            nxt      <= mem_next[head[op_ch]];
            rsp_data <= mem_data[head[op_ch]];
          end
        end
        S_UPD: begin
          st <= S_IDLE;
          if (op_push) begin
            free_head       <= nxt;
            free_cnt        <= free_cnt - 1'b1;
            tail[op_ch]     <= ent;
            nonempty[op_ch] <= 1'b1;
            if (!nonempty[op_ch]) head[op_ch] <= ent;
          end else begin
            free_head <= ent;
            free_cnt  <= free_cnt + 1'b1;
            rsp_valid <= 1'b1;
            if (head[op_ch] == tail[op_ch]) nonempty[op_ch] <= 1'b0;
            else                            head[op_ch]     <= nxt;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_LINK && op_push) mem_data[free_head] <= op_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_next[i] <= AW'(i + 1);
    end else if (st == S_UPD) begin
      if (op_push && nonempty[op_ch]) mem_next[tail[op_ch]] <= ent;
      else if (!op_push)              mem_next[ent]         <= free_head;
    end
  end

  assert_link_then_upd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LINK) |=> (st == S_UPD));
  assert_upd_then_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UPD) |=> (st == S_IDLE));
  assert_push_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_push && full) |=> (err_full && !busy && full));
  assert_pop_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !req_push && chan_empty[req_chan])
      |=> (err_empty && !busy && $stable(chan_empty)));
  assert_rsp_after_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(st == S_UPD && !op_push));
  assert_free_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CNTW'(DEPTH));
  assert_err_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_full, err_empty, rsp_valid}));
endmodule

// File: tb/llq_ctrl_bench.sv
module llq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // fields: push, chan[3:0], data[7:0], kind[1:0] (0 push ok, 1 pop ok, 2 pop empty, 3 push full), expected[7:0]
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 4'd3, 8'h00, 2'd2, 8'h00},
    {1'b1, 4'd0, 8'h11, 2'd0, 8'h00},
    {1'b1, 4'd0, 8'h22, 2'd0, 8'h00},
    {1'b1, 4'd5, 8'hA1, 2'd0, 8'h00},
    {1'b1, 4'd0, 8'h33, 2'd0, 8'h00},
    {1'b1, 4'd5, 8'hA2, 2'd0, 8'h00},
    {1'b0, 4'd5, 8'h00, 2'd1, 8'hA1},
    {1'b0, 4'd0, 8'h00, 2'd1, 8'h11},
    {1'b0, 4'd0, 8'h00, 2'd1, 8'h22},
    {1'b1, 4'd0, 8'h44, 2'd0, 8'h00},
    {1'b0, 4'd5, 8'h00, 2'd1, 8'hA2},
    {1'b0, 4'd5, 8'h00, 2'd2, 8'h00},
    {1'b0, 4'd0, 8'h00, 2'd1, 8'h33},
    {1'b0, 4'd0, 8'h00, 2'd1, 8'h44},
    {1'b0, 4'd0, 8'h00, 2'd2, 8'h00},
    {1'b1, 4'd9, 8'h5C, 2'd0, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_push = 0;
  logic [3:0] req_chan = 0;
  logic [7:0] req_data = 0;
  logic busy, rsp_valid, full, err_full, err_empty;
  logic [7:0] rsp_data;
  logic [15:0] chan_empty;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  llq_ctrl u_llq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_push(req_push),
    .req_chan(req_chan), .req_data(req_data), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .full(full), .chan_empty(chan_empty),
    .err_full(err_full), .err_empty(err_empty));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic push, input logic [3:0] ch, input logic [7:0] d,
                       input logic [1:0] kind, input logic [7:0] exp);
    @(negedge clk);
    req_valid = 1; req_push = push; req_chan = ch; req_data = d;
    @(posedge clk); #1;
    req_valid = 0;
    if (kind >= 2) begin
      check("R2 no busy on reject", busy, 0);
      if (kind == 2) check("R7 err_empty pulse", {err_empty, err_full}, 2'b10);
      else           check("R6 err_full pulse", {err_full, err_empty}, 2'b10);
      @(posedge clk); #1;
      check("R6 R7 pulse width", {err_full, err_empty}, 2'b00);
    end else begin
      check("R2 busy cycle 1", busy, 1);
      @(posedge clk); #1;
      check("R2 busy cycle 2", busy, 1);
      check("R9 no early rsp", rsp_valid, 0);
      @(posedge clk); #1;
      check("R2 busy released", busy, 0);
      check("R9 rsp_valid", rsp_valid, kind == 1);
      if (kind == 1) check("R3 R4 pop data", rsp_data, exp);
      @(posedge clk); #1;
      check("R9 rsp pulse width", rsp_valid, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset empty", chan_empty, 16'hFFFF);
    check("R1 reset flags", {full, busy, rsp_valid, err_full, err_empty}, 5'b0);
    rst_n = 1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++)
      do_op(VEC[i][22], VEC[i][21:18], VEC[i][17:10], VEC[i][9:8], VEC[i][7:0]);
    check("R5 emptiness after table", chan_empty, 16'hFDFF);
    do_op(0, 9, 0, 1, 8'h5C);
    check("R5 last pop empties", chan_empty[9], 1);

    // R2: request held high through the busy cycles is taken once
    @(negedge clk);
    req_valid = 1; req_push = 1; req_chan = 1; req_data = 8'h55;
    @(posedge clk); #1;
    req_push = 0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    req_valid = 0;
    check("R2 ignored while busy", chan_empty[1], 0);
    do_op(0, 1, 0, 1, 8'h55);
    do_op(0, 1, 0, 2, 0);

    // R6 R8: one channel fills the whole array
    for (int i = 0; i < 64; i++) begin
      check("R6 not full early", full, 0);
      do_op(1, 2, 8'(i), 0, 0);
    end
    check("R6 full after 64", full, 1);
    check("R8 one channel holds all", chan_empty, 16'hFFFB);
    do_op(1, 7, 8'hEE, 3, 0);
    check("R6 dropped push", chan_empty[7], 1);
    check("R6 still full", full, 1);
    do_op(0, 2, 0, 1, 8'h00);
    check("R8 pop frees entry", full, 0);
    do_op(1, 7, 8'h77, 0, 0);
    check("R8 refill full", full, 1);
    for (int i = 1; i < 64; i++) do_op(0, 2, 0, 1, 8'(i));
    do_op(0, 7, 0, 1, 8'h77);
    check("R5 R8 all drained", {full, chan_empty}, {1'b0, 16'hFFFF});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule